// File: doc/BRIEF.md
# Raster Position Interrupt Generator

This block watches the line counter, dot counter and field flag of a raster timing unit and raises single-cycle interrupt pulses when the raster reaches positions that software has programmed. Two independent line interrupts fire at the first dot of a chosen line. A third interrupt fires at a chosen dot offset inside a line. That third interrupt can fire once per field, or step forward by a programmed number of half-lines each time it fires, or fire on every half-line.

Programmed line numbers count half-lines. A value L selects raster line 2L while the field flag is 0, and raster line 2L+1 while it is 1. A target that lands on or beyond the total line count never fires. The block also handles a light-gun trigger. It converts the gun's screen coordinate into a raster position, latches the raster position when the beam gets there, and raises a DMA-request pulse. Software reads and writes three 32-bit words through a simple write strobe and a combinational read port.

Top module: `rastirq_gen`

## Requirements
- R1: After reset, all four pulse outputs are low. Reads at word addresses 0 (line interrupts), 1 (position interrupt) and 2 (gun position) all return zero.
- R2: A write to address 0 stores the data ANDed with 0x03FF03FF, and that value reads back. Bits 25:16 hold half-line A and bits 9:0 hold half-line B.
- R3: `irq_line1` (for A) and `irq_line2` (for B) each pulse high for one cycle, in the cycle after the raster inputs show dot 0 of line 2L + field. L is the half-line from the register.
- R4: A line interrupt whose mapped line 2L + field is not below `ras_total` never fires in that field.
- R5: A write to address 1 stores the data ANDed with 0x03FF33FF, and that value reads back. Bits 9:0 hold the line or step count, bits 13:12 the mode and bits 25:16 the dot offset in units of two dots.
- R6: In mode 0, and in mode 3 (which acts as mode 0), `irq_hpos` pulses once per field. It goes high in the cycle after the raster shows line 2L + field at dot 2D.
- R7: When 2D is above `ras_dots` - 1, the dot target becomes `ras_dots` - 1.
- R8: In mode 1, the first target half-line is (raster line >> 1) at the write + N. Each firing adds N. While the target is above `ras_total` >> 1, that amount is subtracted from it.
- R9: Mode 2 behaves as mode 1 with N = 1, so the interrupt fires on every half-line whose mapped line lies inside the field.
- R10: A gun trigger at (x, y) arms a match at half-line (y >> 1) + `vs_lines` and dot x + `hs_width`. When the raster reaches that point, `dma_req` pulses for one cycle. Address 2 then reads the raster line in bits 25:16 and the dot in bits 9:0.
- R11: Writes to address 2 leave the gun position word unchanged.
- R12: While the raster stays on a matching position, a comparator pulses only once. Rewriting its register re-arms it, so it pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_line | input | LINE_W | Current raster line |
| ras_dot | input | DOT_W | Current dot within the line |
| ras_odd | input | 1 | Field flag (1 = odd field) |
| ras_total | input | LINE_W | Raster lines per field |
| ras_dots | input | DOT_W | Dots per line |
| vs_lines | input | VS_W | Vertical sync line count added to the gun row |
| hs_width | input | HS_W | Horizontal sync width added to the gun column |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| gun_trig | input | 1 | Gun trigger, one cycle |
| gun_x | input | DOT_W | Gun screen column |
| gun_y | input | LINE_W | Gun screen row |
| irq_line1 | output | 1 | Line interrupt A pulse |
| irq_line2 | output | 1 | Line interrupt B pulse |
| irq_hpos | output | 1 | Dot-position interrupt pulse |
| dma_req | output | 1 | Gun-capture DMA request pulse |

## Verification
A free-running raster with an odd line count is swept across several fields while a scoreboard predicts every pulse cycle. The sweep covers these cases:
- lines in both field parities, which separates even from odd line mapping;
- a half-line that maps inside the field only in the even field, which exposes wrong range limits;
- dot offsets below and above the line length, which exercise the clamp;
- step counts of 3 and 1, whose targets wrap past half the field, which tells the wrap arithmetic apart from plain addition.

Gun triggers at two coordinates check the sync offsets and the latched word. A frozen raster with a register rewrite separates one-shot edge behaviour from level behaviour.

// File: rtl/rastirq_pkg.sv
package rastirq_pkg;
  localparam int CW       = 16;
  localparam int FLD_W    = 10;
  localparam int DATA_W   = 32;
  localparam int LO_POS   = 0;
  localparam int HI_POS   = 16;
  localparam int MODE_POS = 12;
  localparam logic [DATA_W-1:0] VPOS_MASK = 32'h03FF_03FF;
  localparam logic [DATA_W-1:0] HPOS_MASK = 32'h03FF_33FF;
  localparam int ADR_VPOS = 0;
  localparam int ADR_HPOS = 1;
  localparam int ADR_GUN  = 2;

  typedef logic [CW-1:0] cw_t;

  typedef enum logic [1:0] {
    HM_FRAME      = 2'd0,
    HM_EVERY_N    = 2'd1,
    HM_EVERY_LINE = 2'd2,
    HM_RESERVED   = 2'd3
  } hmode_e;

  // half-line number plus field parity -> raster line
  function automatic cw_t field_line(cw_t half, logic odd);
    return {half[CW-2:0], odd};
  endfunction

  // limit a requested dot to the last dot of the line
  function automatic cw_t clamp_dot(cw_t req, cw_t dots);
    cw_t last;
    last = (dots == '0) ? '0 : dots - cw_t'(1);
    return (req > last) ? last : req;
  endfunction

  // one wrap step of a stepping target
  function automatic cw_t wrap_once(cw_t t, cw_t half);
    return (half != '0 && t > half) ? t - half : t;
  endfunction
endpackage

// File: rtl/rastirq_vcmp.sv
module rastirq_vcmp
  import rastirq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rearm,
  input  logic [FLD_W-1:0]  half_line,
  input  logic [LINE_W-1:0] ras_line,
  input  logic [DOT_W-1:0]  ras_dot,
  input  logic              ras_odd,
  input  logic [LINE_W-1:0] ras_total,
  output logic              irq
);
  cw_t  tgt_line;
  logic match;
  logic hold_r;

  assign tgt_line = field_line(cw_t'(half_line), ras_odd);
  assign match    = (tgt_line < cw_t'(ras_total)) &&
                    (tgt_line == cw_t'(ras_line)) &&
                    (ras_dot == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_r <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq    <= match & ~hold_r;
      hold_r <= rearm ? 1'b0 : match;
    end
  end
endmodule

// File: rtl/rastirq_hpos.sv
module rastirq_hpos
  import rastirq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [FLD_W-1:0]  w_line,
  input  hmode_e            w_mode,
  input  logic [FLD_W-1:0]  w_dot,
  input  logic [LINE_W-1:0] ras_line,
  input  logic [DOT_W-1:0]  ras_dot,
  input  logic              ras_odd,
  input  logic [LINE_W-1:0] ras_total,
  input  logic [DOT_W-1:0]  ras_dots,
  output logic              irq
);
  logic             stepping_r;
  logic [FLD_W-1:0] step_r;
  cw_t              tgt_r;
  logic [FLD_W-1:0] dot_r;
  logic             hold_r;

  cw_t  half_total;
  cw_t  cur_half;
  cw_t  line_tgt;
  cw_t  dot_tgt;
  logic settled;
  logic match;
  logic fire;

  assign half_total = cw_t'(ras_total) >> 1;
  assign cur_half   = cw_t'(ras_line) >> 1;
  assign settled    = !stepping_r || (tgt_r <= half_total);
  assign line_tgt   = field_line(tgt_r, ras_odd);
  assign dot_tgt    = clamp_dot({cw_t'(dot_r), 1'b0}, cw_t'(ras_dots));
  assign match      = settled &&
                      (line_tgt < cw_t'(ras_total)) &&
                      (line_tgt == cw_t'(ras_line)) &&
                      (cw_t'(ras_dot) == dot_tgt);
  assign fire       = match & ~hold_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepping_r <= 1'b0;
      step_r     <= '0;
      tgt_r      <= '0;
      dot_r      <= '0;
      hold_r     <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq    <= fire;
      hold_r <= wr ? 1'b0 : match;
      if (wr) begin
        dot_r <= w_dot;
        unique case (w_mode)
          HM_EVERY_N: begin
            stepping_r <= 1'b1;
            step_r     <= w_line;
            tgt_r      <= cur_half + cw_t'(w_line);
          end
          HM_EVERY_LINE: begin
            stepping_r <= 1'b1;
            step_r     <= FLD_W'(1);
            tgt_r      <= cur_half + cw_t'(1);
          end
          default: begin
            stepping_r <= 1'b0;
            step_r     <= '0;
            tgt_r      <= cw_t'(w_line);
          end
        endcase
      end else if (fire && stepping_r) begin
        tgt_r <= tgt_r + cw_t'(step_r);
      end else if (stepping_r) begin
        tgt_r <= wrap_once(tgt_r, half_total);
      end
    end
  end
endmodule

// File: rtl/rastirq_gun.sv
module rastirq_gun
  import rastirq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10,
  parameter int VS_W   = 4,
  parameter int HS_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [DOT_W-1:0]  gx,
  input  logic [LINE_W-1:0] gy,
  input  logic [VS_W-1:0]   vs_lines,
  input  logic [HS_W-1:0]   hs_width,
  input  logic [LINE_W-1:0] ras_line,
  input  logic [DOT_W-1:0]  ras_dot,
  output logic              armed,
  output logic              dma_req,
  output logic [DATA_W-1:0] pos_word
);
  cw_t               row_r;
  cw_t               col_r;
  logic [LINE_W-1:0] lat_line_r;
  logic [DOT_W-1:0]  lat_dot_r;
  logic              match;

  assign match = armed &&
                 ((cw_t'(ras_line) >> 1) == row_r) &&
                 (cw_t'(ras_dot) == col_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      row_r      <= '0;
      col_r      <= '0;
      lat_line_r <= '0;
      lat_dot_r  <= '0;
      dma_req    <= 1'b0;
    end else begin
      dma_req <= match;
      if (match) begin
        lat_line_r <= ras_line;
        lat_dot_r  <= ras_dot;
      end
      if (trig) begin
        armed <= 1'b1;
        row_r <= (cw_t'(gy) >> 1) + cw_t'(vs_lines);
        col_r <= cw_t'(gx) + cw_t'(hs_width);
      end else if (match) begin
        armed <= 1'b0;
      end
    end
  end

  always_comb begin
    pos_word = '0;
    pos_word[HI_POS +: FLD_W] = FLD_W'(lat_line_r);
    pos_word[LO_POS +: FLD_W] = FLD_W'(lat_dot_r);
  end
endmodule

// File: rtl/rastirq_gen.sv
module rastirq_gen
  import rastirq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10,
  parameter int VS_W   = 4,
  parameter int HS_W   = 7,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] ras_line,
  input  logic [DOT_W-1:0]  ras_dot,
  input  logic              ras_odd,
  input  logic [LINE_W-1:0] ras_total,
  input  logic [DOT_W-1:0]  ras_dots,
  input  logic [VS_W-1:0]   vs_lines,
  input  logic [HS_W-1:0]   hs_width,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              gun_trig,
  input  logic [DOT_W-1:0]  gun_x,
  input  logic [LINE_W-1:0] gun_y,
  output logic              irq_line1,
  output logic              irq_line2,
  output logic              irq_hpos,
  output logic              dma_req
);
  localparam int N_VCMP = 2;
  localparam logic [ADDR_W-1:0] A_VPOS = ADDR_W'(ADR_VPOS);
  localparam logic [ADDR_W-1:0] A_HPOS = ADDR_W'(ADR_HPOS);
  localparam logic [ADDR_W-1:0] A_GUN  = ADDR_W'(ADR_GUN);

  logic [DATA_W-1:0] vpos_q;
  logic [DATA_W-1:0] hpos_q;
  logic [DATA_W-1:0] vpos_w;
  logic [DATA_W-1:0] hpos_w;
  logic              vpos_wr;
  logic              hpos_wr;
  logic [FLD_W-1:0]  vline [N_VCMP];
  logic [N_VCMP-1:0] virq;
  logic              gun_armed;
  logic [DATA_W-1:0] gun_pos;

  assign vpos_w  = bus_wdata & VPOS_MASK;
  assign hpos_w  = bus_wdata & HPOS_MASK;
  assign vpos_wr = bus_wr && (bus_addr == A_VPOS);
  assign hpos_wr = bus_wr && (bus_addr == A_HPOS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpos_q <= '0;
      hpos_q <= '0;
    end else begin
      if (vpos_wr) vpos_q <= vpos_w;
      if (hpos_wr) hpos_q <= hpos_w;
    end
  end

  assign vline[0] = vpos_q[HI_POS +: FLD_W];
  assign vline[1] = vpos_q[LO_POS +: FLD_W];

  for (genvar g = 0; g < N_VCMP; g++) begin : g_vcmp
    rastirq_vcmp #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_vcmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rearm     (vpos_wr),
      .half_line (vline[g]),
      .ras_line  (ras_line),
      .ras_dot   (ras_dot),
      .ras_odd   (ras_odd),
      .ras_total (ras_total),
      .irq       (virq[g])
    );
  end

  assign irq_line1 = virq[0];
  assign irq_line2 = virq[1];

  rastirq_hpos #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_hpos (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (hpos_wr),
    .w_line    (hpos_w[LO_POS +: FLD_W]),
    .w_mode    (hmode_e'(hpos_w[MODE_POS +: 2])),
    .w_dot     (hpos_w[HI_POS +: FLD_W]),
    .ras_line  (ras_line),
    .ras_dot   (ras_dot),
    .ras_odd   (ras_odd),
    .ras_total (ras_total),
    .ras_dots  (ras_dots),
    .irq       (irq_hpos)
  );

  rastirq_gun #(.LINE_W(LINE_W), .DOT_W(DOT_W), .VS_W(VS_W), .HS_W(HS_W)) u_gun (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (gun_trig),
    .gx       (gun_x),
    .gy       (gun_y),
    .vs_lines (vs_lines),
    .hs_width (hs_width),
    .ras_line (ras_line),
    .ras_dot  (ras_dot),
    .armed    (gun_armed),
    .dma_req  (dma_req),
    .pos_word (gun_pos)
  );

  always_comb begin
    unique case (bus_addr)
      A_VPOS:  bus_rdata = vpos_q;
      A_HPOS:  bus_rdata = hpos_q;
      A_GUN:   bus_rdata = gun_pos;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rastirq_chk.sv
module rastirq_chk #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_line1,
  input logic              irq_line2,
  input logic              irq_hpos,
  input logic              dma_req,
  input logic [LINE_W-1:0] ras_line,
  input logic [DOT_W-1:0]  ras_dot,
  input logic              ras_odd,
  input logic [LINE_W-1:0] ras_total,
  input logic [DOT_W-1:0]  ras_dots,
  input logic              gun_trig,
  input logic              gun_armed,
  input logic [31:0]       gun_pos
);
  AST_LINE1_AT_DOT0: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line1 |-> $past(ras_dot) == '0); // R3
  AST_LINE2_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line2 |-> $past(ras_line[0]) == $past(ras_odd)); // R3
  AST_LINE1_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line1 |-> $past(ras_line) < $past(ras_total)); // R4
  AST_HPOS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hpos |-> $past(ras_line[0]) == $past(ras_odd)); // R6
  AST_HPOS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hpos && $past(ras_dots) != '0 |-> $past(ras_dot) < $past(ras_dots)); // R7
  AST_GUN_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !$past(gun_trig) |-> !gun_armed); // R10
  AST_GUN_LATCH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> gun_pos[25:16] == 10'($past(ras_line))); // R10
  AST_GUN_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |-> $stable(gun_pos)); // R11
endmodule

bind rastirq_gen rastirq_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_line1 (irq_line1),
  .irq_line2 (irq_line2),
  .irq_hpos  (irq_hpos),
  .dma_req   (dma_req),
  .ras_line  (ras_line),
  .ras_dot   (ras_dot),
  .ras_odd   (ras_odd),
  .ras_total (ras_total),
  .ras_dots  (ras_dots),
  .gun_trig  (gun_trig),
  .gun_armed (gun_armed),
  .gun_pos   (gun_pos)
);

// File: tb/tb_rastirq_gen.sv
module tb_rastirq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TOTAL = 21;
  localparam int DOTS  = 16;
  localparam int VS    = 2;
  localparam int HS    = 3;
  localparam int FRAME = TOTAL * DOTS;
  localparam int HALF  = TOTAL / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ras_line, ras_dot, ras_total, ras_dots, gun_x, gun_y;
  logic        ras_odd, bus_wr, gun_trig;
  logic [3:0]  vs_lines;
  logic [6:0]  hs_width;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_line1, irq_line2, irq_hpos, dma_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  rastirq_gen dut (
    .clk(clk), .rst_n(rst_n), .ras_line(ras_line), .ras_dot(ras_dot),
    .ras_odd(ras_odd), .ras_total(ras_total), .ras_dots(ras_dots),
    .vs_lines(vs_lines), .hs_width(hs_width), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gun_trig(gun_trig), .gun_x(gun_x), .gun_y(gun_y),
    .irq_line1(irq_line1), .irq_line2(irq_line2), .irq_hpos(irq_hpos),
    .dma_req(dma_req)
  );

  typedef struct { int cyc; int kind; string tag; } exp_t;
  exp_t expq[$];

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  int ln = TOTAL - 1, dt = DOTS - 1, od = 1;
  bit freeze = 0;
  int v1 = 0, v2 = 0;
  bit pv1 = 0, pv2 = 0, ph = 0;
  bit hstep = 0;
  int hl = 0, hd = 0, hn = 0, htgt = 0;
  bit garm = 0;
  int gy = 0, gx = 0, glat = 0;
  string cur_tag = "R6", vtag = "R3";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit on_line(int half);
    return (ln / 2 == half) && (ln % 2 == od) && (2 * half + od < TOTAL);
  endfunction

  function automatic int dot_goal();
    int t = 2 * hd;
    if (t > DOTS - 1) t = DOTS - 1;
    return t;
  endfunction

  function automatic int wrapped(int t);
    int r = t;
    while (r > HALF) r -= HALF;
    return r;
  endfunction

  task automatic push(int kind, string tag);
    exp_t e;
    e.cyc = cyc + 1; e.kind = kind; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic monitor();
    while (expq.size() > 0 && expq[0].cyc < cyc) begin
      checks++; errors++;
      $display("FAIL %s missed pulse kind %0d at cycle %0d: actual=0 expected=1",
               expq[0].tag, expq[0].kind, expq[0].cyc);
      void'(expq.pop_front());
    end
    for (int k = 0; k < 4; k++) begin
      bit o;
      o = (k == 0) ? irq_line1 : (k == 1) ? irq_line2 : (k == 2) ? irq_hpos : dma_req;
      if (o) begin
        checks++;
        if (expq.size() > 0 && expq[0].cyc == cyc && expq[0].kind == k) begin
          void'(expq.pop_front());
        end else begin
          errors++;
          $display("FAIL %s unexpected pulse kind %0d at cycle %0d: actual=1 expected=0",
                   cur_tag, k, cyc);
        end
      end
    end
  endtask

  task automatic step(bit wr = 0, int addr = 0, logic [31:0] data = 0,
                      bit trig = 0, int tx = 0, int ty = 0);
    bit m1, m2, mh, mg;
    @(negedge clk);
    cyc++;
    monitor();
    if (!freeze) begin
      dt++;
      if (dt == DOTS) begin
        dt = 0; ln++;
        if (ln == TOTAL) begin ln = 0; od ^= 1; end
      end
    end
    ras_line = 10'(ln); ras_dot = 10'(dt); ras_odd = od[0];
    bus_wr = wr; bus_addr = 2'(addr); bus_wdata = data;
    gun_trig = trig; gun_x = 10'(tx); gun_y = 10'(ty);
    m1 = on_line(v1) && dt == 0;
    m2 = on_line(v2) && dt == 0;
    mh = on_line(hstep ? htgt : hl) && dt == dot_goal();
    mg = garm && (ln / 2 == gy) && (dt == gx);
    if (m1 && !pv1) push(0, vtag);
    if (m2 && !pv2) push(1, vtag);
    if (mh && !ph) begin
      push(2, cur_tag);
      if (hstep) htgt = wrapped(htgt + hn);
    end
    if (mg) begin push(3, "R10"); garm = 0; glat = (ln << 16) | dt; end
    pv1 = (wr && addr == 0) ? 1'b0 : m1;
    pv2 = (wr && addr == 0) ? 1'b0 : m2;
    ph  = (wr && addr == 1) ? 1'b0 : mh;
    if (trig) begin garm = 1; gy = ty / 2 + VS; gx = tx + HS; end
    if (wr && addr == 0) begin v1 = int'(data[25:16]); v2 = int'(data[9:0]); end
    if (wr && addr == 1) begin
      int md = int'(data[13:12]);
      hd = int'(data[25:16]);
      if (md == 1) begin hstep = 1; hn = int'(data[9:0]); htgt = wrapped(ln / 2 + hn); end
      else if (md == 2) begin hstep = 1; hn = 1; htgt = wrapped(ln / 2 + 1); end
      else begin hstep = 0; hl = int'(data[9:0]); end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rd(int a, output logic [31:0] v);
    step();
    bus_addr = 2'(a);
    #1 v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    ras_line = 10'(ln); ras_dot = 10'(dt); ras_odd = od[0];
    ras_total = 10'(TOTAL); ras_dots = 10'(DOTS);
    vs_lines = 4'(VS); hs_width = 7'(HS);
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    gun_trig = 0; gun_x = 0; gun_y = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({irq_line1, irq_line2, irq_hpos, dma_req} == 4'b0, "R1", "pulses in reset",
        {irq_line1, irq_line2, irq_hpos, dma_req}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 3; a++) begin
      bus_addr = 2'(a);
      #1 chk(bus_rdata == 0, "R1", "reset readback", bus_rdata, 0);
    end

    // reset configuration: half-line 0 everywhere, mode 0 at dot 0
    run(2 * FRAME);

    // register masking
    step(1, 0, 32'hFFFF_FFFF);
    rd(0, v); chk(v == 32'h03FF_03FF, "R2", "line word mask", v, 32'h03FF_03FF);
    step(1, 1, 32'hFFFF_FFFF);
    rd(1, v); chk(v == 32'h03FF_33FF, "R5", "position word mask", v, 32'h03FF_33FF);
    cur_tag = "R4"; vtag = "R4";
    run(FRAME);

    // R3: two lines of differing parity sources
    vtag = "R3"; cur_tag = "R3";
    step(1, 0, 32'h0003_0007);
    run(2 * FRAME);

    // R4: half-line 10 maps inside the field only for even parity
    vtag = "R4"; cur_tag = "R4";
    step(1, 0, 32'h000A_03FF);
    run(2 * FRAME);

    // R6: mode 0 and reserved mode 3
    vtag = "R3"; cur_tag = "R6";
    step(1, 1, (32'd5 << 16) | 32'd4);
    run(2 * FRAME);
    step(1, 1, (32'd3 << 16) | (32'd3 << 12) | 32'd2);
    run(2 * FRAME);

    // R7: dot clamp
    cur_tag = "R7";
    step(1, 1, (32'd20 << 16) | 32'd6);
    run(2 * FRAME);

    // R8: step of three with wrap
    cur_tag = "R8";
    step(1, 1, (32'd1 << 16) | (32'd1 << 12) | 32'd3);
    run(4 * FRAME);

    // R9: every half-line
    cur_tag = "R9";
    step(1, 1, (32'd2 << 16) | (32'd2 << 12));
    run(2 * FRAME);

    // quiet the interrupts
    cur_tag = "R10";
    step(1, 1, 32'h03FF_03FF);
    step(1, 0, 32'h03FF_03FF);

    // R10: gun captures
    step(0, 0, 0, 1, 5, 9);
    run(FRAME);
    rd(2, v); chk(v == 32'(glat), "R10", "gun word A", v, glat);
    chk(glat == ((12 << 16) | 8), "R10", "gun model A", glat, (12 << 16) | 8);
    step(0, 0, 0, 1, 12, 0);
    run(FRAME);
    rd(2, v); chk(v == 32'(glat), "R10", "gun word B", v, glat);

    // R11: gun word ignores writes
    step(1, 2, 32'h1234_5678);
    rd(2, v); chk(v == 32'(glat), "R11", "gun word after write", v, glat);

    // R12: frozen raster on a matching position, then rewrite
    cur_tag = "R12"; vtag = "R12";
    step(1, 0, 32'h0003_03FF);
    for (int i = 0; i < 3 * FRAME; i++) begin
      if (ln == 5 && dt == DOTS - 1 && od == 0) break;
      step();
    end
    step();
    freeze = 1;
    run(6);
    chk(expq.size() == 0, "R12", "one pulse while frozen", expq.size(), 0);
    step(1, 0, 32'h0003_03FF);
    run(6);
    freeze = 0;
    run(4);
    chk(expq.size() == 0, "R12", "scoreboard drained", expq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule